// File: doc/BRIEF.md
# Paged Address Translator with Access Rights

The block sits between a CPU address bus and memory and turns every logical address into a physical one. The upper bits of the logical address select one entry of an on-chip page table. The frame number held in that entry replaces those upper bits. The lower bits, the offset within the 8 KB page, pass through unchanged. Each entry also carries three control bits. They are checked against the CPU's 3-bit function code and its read/write line, so an access that is not allowed never reaches memory.

Supervisor software fills the table through a synchronous write port while the bus is quiet. A translation takes one clocked cycle. The physical strobe follows the logical strobe one cycle later. A refused access gets a single-cycle fault pulse in place of the strobe.

A small state machine runs each access through these states. IDLE waits for a strobe. GRANT drives the physical strobe. DENY pulses the fault. HOLD waits out the rest of a refused access. The transitions are:
- IDLE→GRANT: strobe sampled and the entry permits the access.
- IDLE→DENY: strobe sampled and the entry refuses the access.
- GRANT→IDLE and HOLD→IDLE: strobe dropped.
- DENY→HOLD: strobe still high.
- DENY→IDLE: strobe dropped.

Top module: `page_mapper`

## Requirements
- R1: While reset is held and in the first cycle after it, `phys_stb` and `fault` are 0.
- R2: Bits [12:0] of `phys_addr` equal bits [12:0] of the logical address of the granted access.
- R3: Bits [23:13] of `phys_addr` equal the frame field, bits [10:0], of the table entry indexed by logical address bits [23:13].
- R4: `phys_stb` rises in the cycle after `log_stb` is first sampled high, stays high while `log_stb` stays high, and is 0 in the cycle after `log_stb` is sampled low.
- R5: A table entry is 14 bits: bit 13 valid, bit 12 write-protect, bit 11 supervisor-only, bits [10:0] frame number.
- R6: An access to an entry whose valid bit is 0 raises `fault` and leaves `phys_stb` at 0.
- R7: A write (`rd_nwr`=0) to a write-protected entry faults. A read of the same entry is granted.
- R8: A user access (function code bit 2 = 0) to a supervisor-only entry faults. A supervisor access to it is granted.
- R9: Only function codes 3'b001 (user data), 3'b010 (user program), 3'b101 (supervisor data) and 3'b110 (supervisor program) are legal. Any other code faults.
- R10: A refused access produces exactly one cycle of `fault`, one cycle after the strobe is sampled, however long the strobe is held.
- R11: A table write is ignored while `log_stb` is high or an access is still being served. It takes effect only when the machine is idle and the strobe is low.
- R12: `phys_stb` and `fault` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_addr | input | 24 | Logical address |
| log_stb | input | 1 | Logical address strobe |
| func_code | input | 3 | CPU function code |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 11 | Table entry to write |
| tbl_entry | input | 14 | Entry value to write |
| phys_addr | output | 24 | Translated physical address |
| phys_stb | output | 1 | Physical address strobe |
| fault | output | 1 | Access refused, one-cycle pulse |

## Verification
Every result is due exactly one clock edge after the input that causes it:
- the grant strobe, or the fault pulse, one edge after the logical strobe is raised;
- the strobe's fall one edge after the logical strobe drops.

The driver raises inputs on falling edges and tests the outputs on the next falling edge. That is the single register stage, counted. A scoreboard queue holds the predicted kind of each access (granted with an address, or refused). The monitor pops one item per observed event, so an early, late, missing or extra event shows as a mismatch.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT,
        ST_DENY,
        ST_HOLD
    } pm_state_e;

    localparam logic [2:0] FC_USER_DATA = 3'b001;
    localparam logic [2:0] FC_USER_PROG = 3'b010;
    localparam logic [2:0] FC_SUPV_DATA = 3'b101;
    localparam logic [2:0] FC_SUPV_PROG = 3'b110;

    // R9: only four codes are legal bus cycles
    function automatic logic fc_legal(input logic [2:0] fc);
        return (fc == FC_USER_DATA) || (fc == FC_USER_PROG) ||
               (fc == FC_SUPV_DATA) || (fc == FC_SUPV_PROG);
    endfunction

endpackage

// File: rtl/pm_table.sv
module pm_table #(
    parameter int IDX_W = 11,
    parameter int ENT_W = 14
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [ENT_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/pm_rights.sv
module pm_rights #(
    parameter int FRAME_W = 11
) (
    input  logic [FRAME_W+2:0] entry,
    input  logic [2:0]         fc,
    input  logic               rd_nwr,
    output logic               deny,
    output logic [FRAME_W-1:0] frame
);
    import pm_pkg::*;

    // R5: entry layout {valid, write-protect, supervisor-only, frame}
    localparam int B_VALID = FRAME_W + 2;
    localparam int B_WPROT = FRAME_W + 1;
    localparam int B_SUPV  = FRAME_W;

    logic is_supv;

    always_comb begin
        is_supv = fc[2];
        frame   = entry[FRAME_W-1:0];
        deny    = 1'b0;
        if (!fc_legal(fc))                 deny = 1'b1;  // R9
        if (!entry[B_VALID])               deny = 1'b1;  // R6
        if (!rd_nwr && entry[B_WPROT])     deny = 1'b1;  // R7
        if (!is_supv && entry[B_SUPV])     deny = 1'b1;  // R8
    end

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_in,
    input  logic deny,
    output logic stb_out,
    output logic fault,
    output logic load,
    output logic cfg_ok
);
    import pm_pkg::*;

    pm_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (stb_in) state_nx = deny ? ST_DENY : ST_GRANT;
            ST_GRANT: if (!stb_in) state_nx = ST_IDLE;
            ST_DENY:  state_nx = stb_in ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (!stb_in) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        stb_out = (state == ST_GRANT);
        fault   = (state == ST_DENY);
        load    = (state == ST_IDLE) && stb_in && !deny;
        cfg_ok  = (state == ST_IDLE) && !stb_in;   // R11
    end

endmodule

// File: rtl/page_mapper.sv
module page_mapper #(
    parameter int LA_W    = 24,
    parameter int OFF_W   = 13,
    parameter int FRAME_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LA_W-1:0]        log_addr,
    input  logic                   log_stb,
    input  logic [2:0]             func_code,
    input  logic                   rd_nwr,
    input  logic                   tbl_we,
    input  logic [LA_W-OFF_W-1:0]  tbl_idx,
    input  logic [FRAME_W+2:0]     tbl_entry,
    output logic [FRAME_W+OFF_W-1:0] phys_addr,
    output logic                   phys_stb,
    output logic                   fault
);
    localparam int IDX_W = LA_W - OFF_W;
    localparam int ENT_W = FRAME_W + 3;
    localparam int PA_W  = FRAME_W + OFF_W;

    logic [ENT_W-1:0]   entry;
    logic [FRAME_W-1:0] frame;
    logic               deny;
    logic               load;
    logic               cfg_ok;
    logic [PA_W-1:0]    pa_q;

    pm_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
        .clk   (clk),
        .we    (tbl_we && cfg_ok),
        .widx  (tbl_idx),
        .wdata (tbl_entry),
        .ridx  (log_addr[LA_W-1:OFF_W]),
        .rdata (entry)
    );

    pm_rights #(.FRAME_W(FRAME_W)) u_rights (
        .entry  (entry),
        .fc     (func_code),
        .rd_nwr (rd_nwr),
        .deny   (deny),
        .frame  (frame)
    );

    pm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_in  (log_stb),
        .deny    (deny),
        .stb_out (phys_stb),
        .fault   (fault),
        .load    (load),
        .cfg_ok  (cfg_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q <= '0;
        end else if (load) begin
            pa_q <= {frame, log_addr[OFF_W-1:0]};
        end
    end

    assign phys_addr = pa_q;

endmodule

// File: rtl/page_mapper_checker.sv
module page_mapper_checker #(
    parameter int LA_W  = 24,
    parameter int OFF_W = 13,
    parameter int PA_W  = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            log_stb,
    input logic [LA_W-1:0] log_addr,
    input logic [PA_W-1:0] phys_addr,
    input logic            phys_stb,
    input logic            fault
);
    assert_pstb_after_lstb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phys_stb) |-> $past(log_stb));

    assert_pstb_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !log_stb |=> !phys_stb);

    assert_pstb_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_stb && log_stb) |=> phys_stb);

    assert_fault_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    assert_fault_no_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !phys_stb);

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(phys_stb && fault));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phys_stb) |-> (phys_addr[OFF_W-1:0] == $past(log_addr[OFF_W-1:0])));

endmodule

bind page_mapper page_mapper_checker #(
    .LA_W(LA_W), .OFF_W(OFF_W), .PA_W(FRAME_W + OFF_W)
) u_page_mapper_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_stb   (log_stb),
    .log_addr  (log_addr),
    .phys_addr (phys_addr),
    .phys_stb  (phys_stb),
    .fault     (fault)
);

// File: tb/page_mapper_bench.sv
module page_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] log_addr = '0;
    logic        log_stb = 1'b0;
    logic [2:0]  func_code = 3'b101;
    logic        rd_nwr = 1'b1;
    logic        tbl_we = 1'b0;
    logic [10:0] tbl_idx = '0;
    logic [13:0] tbl_entry = '0;
    logic [23:0] phys_addr;
    logic        phys_stb;
    logic        fault;

    always #5 clk = ~clk;

    page_mapper u_page_mapper (
        .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .log_stb(log_stb),
        .func_code(func_code), .rd_nwr(rd_nwr), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_entry(tbl_entry), .phys_addr(phys_addr),
        .phys_stb(phys_stb), .fault(fault)
    );

    typedef struct packed {
        logic        flt;
        logic [23:0] pa;
        logic [7:0]  req;
    } exp_t;

    exp_t        sb[$];
    logic [13:0] model [2048];
    int          n_chk = 0;
    int          n_fail = 0;
    logic        prev_stb = 1'b0;
    logic        done = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5, R6, R7, R8, R9: expected refusal from entry layout {v,wp,so,frame}
    function automatic logic predict_deny(input logic [13:0] e, input logic [2:0] fc, input logic rnw);
        logic legal;
        legal = (fc == 3'b001) || (fc == 3'b010) || (fc == 3'b101) || (fc == 3'b110);
        return !legal || !e[13] || (!rnw && e[12]) || (!fc[2] && e[11]);
    endfunction

    task automatic load_entry(input logic [10:0] idx, input logic [13:0] ent);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_entry = ent;
        model[idx] = ent;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic access(input logic [23:0] la, input logic [2:0] fc, input logic rnw,
                          input int hold, input string req);
        exp_t e;
        logic dn;
        dn = predict_deny(model[la[23:13]], fc, rnw);
        e.flt = dn;
        e.pa  = {model[la[23:13]][10:0], la[12:0]};
        e.req = 8'd0;
        @(negedge clk);
        log_addr = la; func_code = fc; rd_nwr = rnw; log_stb = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        chk(phys_stb == !dn, {req, " R4 strobe one cycle after request"}, {31'd0, phys_stb}, {31'd0, !dn});
        chk(fault == dn, {req, " R10 fault pulse timing"}, {31'd0, fault}, {31'd0, dn});
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            chk(phys_stb == !dn, {req, " R4 strobe held"}, {31'd0, phys_stb}, {31'd0, !dn});
            chk(fault == 1'b0, {req, " R10 single fault"}, {31'd0, fault}, 32'd0);
        end
        log_stb = 1'b0;
        @(negedge clk);
        chk(phys_stb == 1'b0, {req, " R4 strobe drops"}, {31'd0, phys_stb}, 32'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (phys_stb && fault) begin
                chk(1'b0, "R12 strobe and fault together", 32'd1, 32'd0);
            end
            if ((phys_stb && !prev_stb) || fault) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4 unexpected bus event", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(fault == e.flt, "R6 R7 R8 R9 grant or refuse", {31'd0, fault}, {31'd0, e.flt});
                    if (!e.flt && !fault) begin
                        chk(phys_addr[12:0] == e.pa[12:0], "R2 offset", {19'd0, phys_addr[12:0]}, {19'd0, e.pa[12:0]});
                        chk(phys_addr[23:13] == e.pa[23:13], "R3 frame", {21'd0, phys_addr[23:13]}, {21'd0, e.pa[23:13]});
                    end
                end
            end
        end
        prev_stb <= phys_stb;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) model[i] = 14'h0;
        repeat (3) @(negedge clk);
        chk(phys_stb == 1'b0 && fault == 1'b0, "R1 outputs in reset", {30'd0, phys_stb, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phys_stb == 1'b0 && fault == 1'b0, "R1 outputs after reset", {30'd0, phys_stb, fault}, 32'd0);

        // R5 layout: bit13 valid, bit12 wp, bit11 supv-only, [10:0] frame
        load_entry(11'd0,    {3'b100, 11'h155});
        load_entry(11'd7,    {3'b100, 11'h7FF});
        load_entry(11'd2047, {3'b100, 11'h001});
        load_entry(11'd3,    {3'b110, 11'h0A0});
        load_entry(11'd4,    {3'b101, 11'h3C3});
        load_entry(11'd5,    {3'b100, 11'h222});
        load_entry(11'd6,    {3'b000, 11'h444});

        access({11'd0, 13'h1FFF}, 3'b101, 1'b1, 1, "R3 R2 idx0");
        access({11'd7, 13'h0000}, 3'b001, 1'b0, 3, "R3 R4 user write held");
        access({11'd2047, 13'h0ABC}, 3'b110, 1'b1, 2, "R3 top index");
        access({11'd6, 13'h0010}, 3'b101, 1'b1, 2, "R6 invalid");
        access({11'd3, 13'h0020}, 3'b001, 1'b0, 1, "R7 write to protected");
        access({11'd3, 13'h0021}, 3'b001, 1'b1, 1, "R7 read of protected");
        access({11'd4, 13'h0030}, 3'b010, 1'b1, 2, "R8 user to supv page");
        access({11'd4, 13'h0031}, 3'b110, 1'b1, 1, "R8 supv to supv page");
        access({11'd5, 13'h0040}, 3'b000, 1'b1, 1, "R9 code 000");
        access({11'd5, 13'h0041}, 3'b111, 1'b1, 4, "R9 code 111 R10 held");
        access({11'd5, 13'h0042}, 3'b011, 1'b1, 1, "R9 code 011");
        access({11'd5, 13'h0043}, 3'b100, 1'b1, 1, "R9 code 100");
        access({11'd5, 13'h0044}, 3'b010, 1'b1, 1, "R9 code 010 legal");

        // R11: write attempted during a granted access is ignored
        begin
            exp_t e;
            @(negedge clk);
            log_addr = {11'd5, 13'h0100}; func_code = 3'b101; rd_nwr = 1'b1; log_stb = 1'b1;
            tbl_we = 1'b1; tbl_idx = 11'd5; tbl_entry = {3'b100, 11'h6E6};
            e.flt = 1'b0; e.pa = {11'h222, 13'h0100}; e.req = 8'd0;
            sb.push_back(e);
            @(negedge clk);
            tbl_we = 1'b1;
            @(negedge clk);
            tbl_we = 1'b0;
            chk(phys_stb == 1'b1, "R11 access unaffected", {31'd0, phys_stb}, 32'd1);
            log_stb = 1'b0;
            @(negedge clk);
        end
        access({11'd5, 13'h0101}, 3'b101, 1'b1, 1, "R11 entry kept after blocked write");

        // R11: idle write takes effect
        load_entry(11'd5, {3'b100, 11'h6E6});
        access({11'd5, 13'h0102}, 3'b001, 1'b1, 1, "R11 idle write applied");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R4 all expected events seen", sb.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule